// File: doc/BRIEF.md
# ROM integrity check sequencer

This block is the control state machine behind a power-up integrity check of a read-only memory. An external address counter sweeps the memory. While the sweep is in the low region, every word read is offered to an external hash engine over a valid/ready stream, and the final low word carries a last flag. After that word is accepted, the sweep continues into the high region, which holds the expected digest. The sequencer raises a capture enable so that those words can be collected.

The sweep and the hash engine may finish in either order. Once both have reported done, the sequencer issues a one-cycle start to a digest comparator and waits for the comparator's done. It then rests in a pass state. A done event that arrives in a state where it cannot legally occur locks the machine in a failure state, which only reset clears, and the block raises an alert. The alert also passes through a comparator alert and an unexpected-counter-change indication. The counter, the hash engine and the comparator sit outside this block.

The states are ST_RD_LO (reset state, streaming the low region), ST_RD_HI (reading the digest region), ST_MEM_AHEAD (sweep finished, hash pending), ST_HASH_AHEAD (hash finished, sweep pending), ST_COMPARE, ST_PASS and ST_LOCKED. The transitions are:
- ST_RD_LO→ST_RD_HI
- ST_RD_HI→ST_MEM_AHEAD, ST_RD_HI→ST_HASH_AHEAD, ST_RD_HI→ST_COMPARE
- ST_MEM_AHEAD→ST_COMPARE
- ST_HASH_AHEAD→ST_COMPARE
- ST_COMPARE→ST_PASS
- any state→ST_LOCKED, on an error or an out-of-order event.

Top module: `rom_check_seq`

## Requirements
- R1: Reset (rst_ni low, asynchronous) puts the machine in ST_RD_LO. state_o carries the state code: ST_RD_LO=0, ST_RD_HI=1, ST_MEM_AHEAD=2, ST_HASH_AHEAD=3, ST_COMPARE=4, ST_PASS=5, ST_LOCKED=6. Code 7 is handled as ST_LOCKED.
- R2: hash_vld_o equals word_vld_i in ST_RD_LO and is 0 in every other state. hash_last_o is hash_vld_o AND word_last_i, so it is never high without valid.
- R3: ST_RD_LO moves to ST_RD_HI only on a clock edge where hash_vld_o, hash_rdy_i and word_last_i are all high. Otherwise it stays in ST_RD_LO.
- R4: In ST_RD_HI, the pair {hash_done_i, sweep_done_i} selects the next state: 01 goes to ST_MEM_AHEAD, 10 goes to ST_HASH_AHEAD, 11 goes to ST_COMPARE, and 00 stays. hash_err_i high together with hash_done_i goes to ST_LOCKED instead. hash_err_i without hash_done_i is ignored.
- R5: ST_MEM_AHEAD waits for hash_done_i, then goes to ST_COMPARE, or to ST_LOCKED if hash_err_i is high. ST_HASH_AHEAD waits for sweep_done_i, then goes to ST_COMPARE and ignores hash_err_i.
- R6: ST_COMPARE moves to ST_PASS on cmp_done_i. ST_PASS holds. pass_o is high exactly in ST_PASS.
- R7: The next state is forced to ST_LOCKED in three cases, which take priority over R3 to R6: cmp_done_i outside ST_COMPARE and ST_PASS, sweep_done_i in ST_RD_LO, or hash_done_i outside ST_RD_HI and ST_MEM_AHEAD.
- R8: cmp_start_o is a registered, single-cycle pulse. It is high in the first cycle spent in ST_COMPARE and low otherwise.
- R9: alert_o is the OR of three terms: state is ST_LOCKED, cmp_alert_i, and cnt_jump_i. It is combinational.
- R10: rd_gnt_o is rd_req_i AND (state is ST_RD_LO) AND NOT word_last_i. step_o is high in ST_RD_HI and ST_HASH_AHEAD, is hash_rdy_i in ST_RD_LO, and is 0 in all other states.
- R11: digest_cap_o is high in ST_RD_HI or ST_HASH_AHEAD while sweep_done_i is low.
- R12: ST_LOCKED is left only by reset. alert_o stays high throughout it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| word_vld_i | input | 1 | Memory word available for the hash stream |
| word_last_i | input | 1 | Counter is at the final low-region word |
| rd_req_i | input | 1 | Counter requests a further read |
| sweep_done_i | input | 1 | Counter has swept the whole memory |
| cnt_jump_i | input | 1 | Counter changed unexpectedly |
| hash_rdy_i | input | 1 | Hash engine accepts a word |
| hash_done_i | input | 1 | Hash engine finished its digest |
| hash_err_i | input | 1 | Hash engine error, qualified by hash_done_i |
| cmp_done_i | input | 1 | Comparator finished |
| cmp_alert_i | input | 1 | Comparator alert |
| rd_gnt_o | output | 1 | Read request granted |
| step_o | output | 1 | Counter may advance |
| hash_vld_o | output | 1 | Stream valid to the hash engine |
| hash_last_o | output | 1 | Stream last flag |
| digest_cap_o | output | 1 | Capture enable for expected-digest words |
| cmp_start_o | output | 1 | Comparator start pulse |
| pass_o | output | 1 | Check passed |
| alert_o | output | 1 | Integrity alert |
| state_o | output | 3 | Current state code |

## Verification
The combinational outputs rd_gnt_o, step_o, hash_vld_o, hash_last_o, digest_cap_o, alert_o and pass_o follow the inputs within the same cycle, based on the current state. The bench drives each vector on a falling edge and checks these outputs 1 ns later, before the rising edge. The next state appears on state_o one rising edge after the vector is applied, and cmp_start_o is registered on that same edge. Both are checked 1 ns after that edge. Reset is asynchronous, so reset vectors are checked only after the edge.

// File: rtl/rics_pkg.sv
package rics_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_RD_LO      = 3'd0,
        ST_RD_HI      = 3'd1,
        ST_MEM_AHEAD  = 3'd2,
        ST_HASH_AHEAD = 3'd3,
        ST_COMPARE    = 3'd4,
        ST_PASS       = 3'd5,
        ST_LOCKED     = 3'd6
    } seq_state_e;

endpackage

// File: rtl/rics_next_state.sv
module rics_next_state
    import rics_pkg::*;
(
    input  seq_state_e state_q,
    input  logic       word_vld_i,
    input  logic       word_last_i,
    input  logic       hash_rdy_i,
    input  logic       sweep_done_i,
    input  logic       hash_done_i,
    input  logic       hash_err_i,
    input  logic       cmp_done_i,
    output seq_state_e state_d
);

    logic       last_accept;
    logic       bad_event;
    seq_state_e nominal;

    assign last_accept = word_vld_i & hash_rdy_i & word_last_i;

    // Ordinary progress through the check
    always_comb begin
        nominal = state_q;
        unique case (state_q)
            ST_RD_LO: begin
                if (last_accept) begin
                    nominal = ST_RD_HI;
                end
            end
            ST_RD_HI: begin
                unique case ({hash_done_i, sweep_done_i})
                    2'b01:   nominal = ST_MEM_AHEAD;
                    2'b10:   nominal = hash_err_i ? ST_LOCKED : ST_HASH_AHEAD;
                    2'b11:   nominal = hash_err_i ? ST_LOCKED : ST_COMPARE;
                    default: nominal = ST_RD_HI;
                endcase
            end
            ST_MEM_AHEAD: begin
                if (hash_done_i) begin
                    nominal = hash_err_i ? ST_LOCKED : ST_COMPARE;
                end
            end
            ST_HASH_AHEAD: begin
                if (sweep_done_i) begin
                    nominal = ST_COMPARE;
                end
            end
            ST_COMPARE: begin
                if (cmp_done_i) begin
                    nominal = ST_PASS;
                end
            end
            ST_PASS:   nominal = ST_PASS;
            ST_LOCKED: nominal = ST_LOCKED;
            default:   nominal = ST_LOCKED;
        endcase
    end

    // Events that cannot occur in the current state
    always_comb begin
        bad_event = 1'b0;
        if (cmp_done_i && !(state_q inside {ST_COMPARE, ST_PASS})) begin
            bad_event = 1'b1;
        end
        if (sweep_done_i && (state_q == ST_RD_LO)) begin
            bad_event = 1'b1;
        end
        if (hash_done_i && !(state_q inside {ST_RD_HI, ST_MEM_AHEAD})) begin
            bad_event = 1'b1;
        end
    end

    assign state_d = bad_event ? ST_LOCKED : nominal;

endmodule

// File: rtl/rics_state_reg.sv
module rics_state_reg
    import rics_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  seq_state_e state_d,
    output seq_state_e state_q
);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_RD_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // R12: the locked state is left only through reset
    a_r12_locked_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_LOCKED) |=> (state_q == ST_LOCKED));

endmodule

// File: rtl/rics_outputs.sv
module rics_outputs
    import rics_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  seq_state_e state_q,
    input  seq_state_e state_d,
    input  logic       word_vld_i,
    input  logic       word_last_i,
    input  logic       rd_req_i,
    input  logic       sweep_done_i,
    input  logic       hash_rdy_i,
    input  logic       cmp_alert_i,
    input  logic       cnt_jump_i,
    output logic       rd_gnt_o,
    output logic       step_o,
    output logic       hash_vld_o,
    output logic       hash_last_o,
    output logic       digest_cap_o,
    output logic       cmp_start_o,
    output logic       pass_o,
    output logic       alert_o
);

    logic start_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            start_q <= 1'b0;
        end else begin
            start_q <= (state_q != ST_COMPARE) && (state_d == ST_COMPARE);
        end
    end

    always_comb begin
        rd_gnt_o     = 1'b0;
        step_o       = 1'b0;
        hash_vld_o   = 1'b0;
        digest_cap_o = 1'b0;
        pass_o       = 1'b0;
        unique case (state_q)
            ST_RD_LO: begin
                hash_vld_o = word_vld_i;
                rd_gnt_o   = rd_req_i & ~word_last_i;
                step_o     = hash_rdy_i;
            end
            ST_RD_HI, ST_HASH_AHEAD: begin
                step_o       = 1'b1;
                digest_cap_o = ~sweep_done_i;
            end
            ST_PASS: pass_o = 1'b1;
            default: ;
        endcase
    end

    assign hash_last_o = hash_vld_o & word_last_i;
    assign cmp_start_o = start_q;
    assign alert_o     = (state_q == ST_LOCKED) | cmp_alert_i | cnt_jump_i;

    // R8: the start strobe never lasts two cycles
    a_r8_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmp_start_o |=> !cmp_start_o);

    // R8: the start strobe is only seen while comparing
    a_r8_start_in_compare: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmp_start_o |-> (state_q == ST_COMPARE));

endmodule

// File: rtl/rom_check_seq.sv
module rom_check_seq
    import rics_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               word_vld_i,
    input  logic               word_last_i,
    input  logic               rd_req_i,
    input  logic               sweep_done_i,
    input  logic               cnt_jump_i,
    input  logic               hash_rdy_i,
    input  logic               hash_done_i,
    input  logic               hash_err_i,
    input  logic               cmp_done_i,
    input  logic               cmp_alert_i,
    output logic               rd_gnt_o,
    output logic               step_o,
    output logic               hash_vld_o,
    output logic               hash_last_o,
    output logic               digest_cap_o,
    output logic               cmp_start_o,
    output logic               pass_o,
    output logic               alert_o,
    output logic [STATE_W-1:0] state_o
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       vld_gated;

    assign vld_gated = word_vld_i & (state_q == ST_RD_LO);

    rics_next_state i_next (
        .state_q      (state_q),
        .word_vld_i   (vld_gated),
        .word_last_i  (word_last_i),
        .hash_rdy_i   (hash_rdy_i),
        .sweep_done_i (sweep_done_i),
        .hash_done_i  (hash_done_i),
        .hash_err_i   (hash_err_i),
        .cmp_done_i   (cmp_done_i),
        .state_d      (state_d)
    );

    rics_state_reg i_reg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .state_d (state_d),
        .state_q (state_q)
    );

    rics_outputs i_out (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .state_q      (state_q),
        .state_d      (state_d),
        .word_vld_i   (word_vld_i),
        .word_last_i  (word_last_i),
        .rd_req_i     (rd_req_i),
        .sweep_done_i (sweep_done_i),
        .hash_rdy_i   (hash_rdy_i),
        .cmp_alert_i  (cmp_alert_i),
        .cnt_jump_i   (cnt_jump_i),
        .rd_gnt_o     (rd_gnt_o),
        .step_o       (step_o),
        .hash_vld_o   (hash_vld_o),
        .hash_last_o  (hash_last_o),
        .digest_cap_o (digest_cap_o),
        .cmp_start_o  (cmp_start_o),
        .pass_o       (pass_o),
        .alert_o      (alert_o)
    );

    assign state_o = state_q;

    // R2: last is never flagged without valid
    a_r2_last_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hash_last_o |-> hash_vld_o);

    // R3: entry to the high region only follows an accepted last word
    a_r3_enter_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_q == ST_RD_HI) && ($past(state_q) == ST_RD_LO))
            |-> $past(hash_vld_o && hash_rdy_i && hash_last_o));

    // R6: pass holds while no hash done arrives
    a_r6_pass_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_q == ST_PASS) && !hash_done_i) |=> (state_q == ST_PASS));

    // R7: comparator done out of place locks the machine
    a_r7_stray_cmp_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmp_done_i && !(state_q inside {ST_COMPARE, ST_PASS})) |=> (state_q == ST_LOCKED));

    // R9: locked always alerts
    a_r9_alert_when_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_LOCKED) |-> alert_o);

endmodule

// File: tb/test_rom_check_seq.sv
module test_rom_check_seq;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_ni;
    logic       word_vld, word_last, rd_req, sweep_done, cnt_jump;
    logic       hash_rdy, hash_done, hash_err, cmp_done, cmp_alert;
    logic       rd_gnt, step, hash_vld, hash_last, digest_cap, cmp_start, pass, alert;
    logic [2:0] state;

    int applied = 0;
    int bad     = 0;
    bit ended   = 0;

    rom_check_seq i_rom_check_seq (
        .clk_i(clk), .rst_ni(rst_ni), .word_vld_i(word_vld), .word_last_i(word_last),
        .rd_req_i(rd_req), .sweep_done_i(sweep_done), .cnt_jump_i(cnt_jump),
        .hash_rdy_i(hash_rdy), .hash_done_i(hash_done), .hash_err_i(hash_err),
        .cmp_done_i(cmp_done), .cmp_alert_i(cmp_alert), .rd_gnt_o(rd_gnt),
        .step_o(step), .hash_vld_o(hash_vld), .hash_last_o(hash_last),
        .digest_cap_o(digest_cap), .cmp_start_o(cmp_start), .pass_o(pass),
        .alert_o(alert), .state_o(state)
    );

    // State codes (R1)
    localparam logic [2:0] LO = 3'd0, HI = 3'd1, MA = 3'd2, HA = 3'd3,
                           CMP = 3'd4, PAS = 3'd5, LCK = 3'd6;

    // {rst}_{vld rdy last}_{sweep hdone herr cdone}_{calert jump req}_{next state}
    localparam int NV = 55;
    localparam logic [13:0] VEC [NV] = '{
        14'b0_100_0000_001_000, 14'b0_110_0000_001_000, 14'b0_101_0000_001_000,
        14'b0_011_0000_000_000, 14'b0_111_0000_000_001, 14'b0_000_0000_000_001,
        14'b0_000_1000_000_010, 14'b0_000_0000_000_010, 14'b0_000_0100_000_100,
        14'b0_000_0000_000_100, 14'b0_000_0001_000_101, 14'b0_000_0001_000_101,
        14'b0_000_0000_100_101, 14'b0_000_0000_010_101, 14'b0_000_1000_000_101,
        14'b0_000_0100_000_110, 14'b0_000_0000_000_110, 14'b0_111_0000_001_110,
        14'b1_000_0000_000_000, 14'b0_111_0000_000_001, 14'b0_000_0100_000_011,
        14'b0_010_0000_000_011, 14'b0_000_1000_000_100, 14'b0_000_0001_000_101,
        14'b1_000_0000_000_000, 14'b0_111_0000_000_001, 14'b0_000_1100_000_100,
        14'b0_000_0101_000_110, 14'b1_000_0000_000_000, 14'b0_111_0000_000_001,
        14'b0_000_0110_000_110, 14'b1_000_0000_000_000, 14'b0_111_0000_000_001,
        14'b0_000_1000_000_010, 14'b0_000_0110_000_110, 14'b1_000_0000_000_000,
        14'b0_000_1000_000_110, 14'b1_000_0000_000_000, 14'b0_000_0001_000_110,
        14'b1_000_0000_000_000, 14'b0_000_0100_000_110, 14'b1_000_0000_000_000,
        14'b0_111_0000_000_001, 14'b0_000_0001_000_110, 14'b1_000_0000_000_000,
        14'b0_111_0000_000_001, 14'b0_000_1010_000_010, 14'b1_000_0000_000_000,
        14'b0_111_0000_000_001, 14'b0_000_0100_000_011, 14'b0_000_1010_000_100,
        14'b1_000_0000_000_000, 14'b0_111_0000_000_001, 14'b0_000_0100_000_011,
        14'b0_000_0100_000_110
    };

    task automatic check(input string req, input string what,
                         input logic [2:0] act, input logic [2:0] exp);
        applied++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [13:0] v);
        rst_ni     = ~v[13];
        word_vld   = v[12]; hash_rdy  = v[11]; word_last = v[10];
        sweep_done = v[9];  hash_done = v[8];  hash_err  = v[7]; cmp_done = v[6];
        cmp_alert  = v[5];  cnt_jump  = v[4];  rd_req    = v[3];
    endtask

    // Expected combinational outputs from the current state (R2, R6, R9, R10, R11)
    task automatic check_comb(input logic [2:0] s);
        logic ev;
        ev = (s == LO) & word_vld;
        check("R2", "hash_vld", {2'b0, hash_vld}, {2'b0, ev});
        check("R2", "hash_last", {2'b0, hash_last}, {2'b0, ev & word_last});
        check("R10", "rd_gnt", {2'b0, rd_gnt}, {2'b0, rd_req & (s == LO) & ~word_last});
        check("R10", "step", {2'b0, step},
              {2'b0, ((s == LO) & hash_rdy) | (s == HI) | (s == HA)});
        check("R11", "digest_cap", {2'b0, digest_cap},
              {2'b0, ((s == HI) | (s == HA)) & ~sweep_done});
        check("R9", "alert", {2'b0, alert}, {2'b0, (s == LCK) | cmp_alert | cnt_jump});
        check("R6", "pass", {2'b0, pass}, {2'b0, s == PAS});
    endtask

    function automatic string state_tag(input logic r, input logic [2:0] p, input logic [2:0] e);
        if (r)               return "R1";
        if (p == LCK)        return "R12";
        if (e == LCK)        return "R7";
        if (p == LO)         return "R3";
        if (p == HI)         return "R4";
        if (p == MA || p == HA) return "R5";
        return "R6";
    endfunction

    initial begin
        #1_000_000;
        if (!ended) begin
            bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

    initial begin
        logic [2:0] prev;
        drive(14'b1_000_0000_000_000);
        repeat (2) @(posedge clk);
        #1;
        // R1 reset state and quiet outputs
        check("R1", "state", state, LO);
        check("R1", "cmp_start", {2'b0, cmp_start}, 3'd0);
        check("R1", "alert", {2'b0, alert}, 3'd0);
        prev = LO;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            #1;
            if (!VEC[i][13]) check_comb(prev);
            @(posedge clk);
            #1;
            check(state_tag(VEC[i][13], prev, VEC[i][2:0]), "state", state, VEC[i][2:0]);
            check("R8", "cmp_start", {2'b0, cmp_start},
                  {2'b0, (VEC[i][2:0] == CMP) && (prev != CMP) && !VEC[i][13]});
            prev = VEC[i][2:0];
        end
        // R12 directed: reach lock, hold several cycles, then reset clears it
        @(negedge clk);
        drive(14'b0_000_0001_000_000);
        @(negedge clk);
        drive(14'b0_111_0100_000_000);
        repeat (3) @(negedge clk);
        #1;
        check("R12", "state held", state, LCK);
        check("R12", "alert held", {2'b0, alert}, 3'd1);
        drive(14'b1_000_0000_000_000);
        #1;
        check("R1", "async reset", state, LO);
        check("R1", "alert after reset", {2'b0, alert}, 3'd0);
        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

endmodule